// File: doc/BRIEF.md
# Frame-Exact Pulse Density Modulator

This block turns a digital level into a one-bit stream. The fraction of high ticks in the stream is proportional to the level. Time advances only on clock cycles where the tick enable is high. A frame is 2^W ticks long. The level is captured on the first tick of each frame and stays in use until the frame ends, so the stream carries exactly as many high ticks as the captured level within each frame.

The high ticks are spread as evenly as a first-order accumulator allows. Half scale gives a strict low/high alternation. Each step below half scale removes one isolated high tick from that pattern, and each step above half scale merges one extra high into a neighbour. Besides the registered density bit, the block offers a gated output. This output passes the tick pulse only while the registered decision is high, so a gated pulse is never cut short.

Top module: `pulse_density_mod`

## Requirements
- R1: With `rst` high at a clock edge, the next state has `dens_o` low and the frame position at its start, so the following enabled tick begins a new frame.
- R2: Every complete frame of 2^W enabled ticks, with no reset inside it, produces exactly as many high values of `dens_o` as the level captured for that frame.
- R3: On the j-th enabled tick of a frame (j = 1 .. 2^W) with captured level L, `dens_o` becomes 1 exactly when floor(j*L/2^W) exceeds floor((j-1)*L/2^W), and 0 otherwise.
- R4: `level_i` is sampled only on the first enabled tick of a frame. Changes at any other time have no effect on the output until the next frame.
- R5: When `tick_i` is low at a clock edge, `dens_o` and all internal state keep their values.
- R6: `gated_o` is high only while `tick_i` is high and the registered `dens_o` is high. Because `dens_o` only changes at clock edges, a gated pulse spans the whole tick.
- R7: A level of 2^(W-1) gives a strict alternation within the frame: low after the first tick, high after the second, and so on.
- R8: A level of 0 keeps `dens_o` low for the whole frame. A level of 2^W-1 keeps it high on every tick of the frame except the first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_i | input | 1 | Tick enable; the modulator advances one step when high |
| level_i | input | W | Density level, captured at the frame start |
| dens_o | output | 1 | Registered density decision |
| gated_o | output | 1 | Tick pulse gated by the registered decision |

## Verification
The bench builds two instances that share the clock, reset and tick. One uses the default W = 8, so the frame is 256 ticks. It receives directed levels (half scale, one and two below it, one above it, 0, 1 and full scale) and then random levels. The other uses W = 3, so its frames last only 8 ticks. Its level changes on almost every cycle, which gives thousands of frame boundaries and mid-frame level changes that must be ignored. That many boundaries could not be reached with 256-tick frames in the same run time. Random gaps in the tick enable and a reset in the middle of a frame test both widths at once.

// File: rtl/pulse_density_mod.sv
module pulse_density_mod #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick_i,
  input  logic [W-1:0] level_i,
  output logic         dens_o,
  output logic         gated_o
);

  logic [W-1:0] cnt_q, lvl_q, acc_q;
  logic         dens_q;

  wire          first   = (cnt_q == '0);
  wire  [W-1:0] cur_lvl = first ? level_i : lvl_q;
  wire  [W-1:0] base    = first ? '0 : acc_q;
  wire  [W:0]   sum     = {1'b0, base} + {1'b0, cur_lvl};

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      lvl_q  <= '0;
      acc_q  <= '0;
      dens_q <= 1'b0;
    end else if (tick_i) begin
      cnt_q  <= cnt_q + 1'b1;
      lvl_q  <= cur_lvl;
      acc_q  <= sum[W-1:0];
      dens_q <= sum[W];
    end
  end

  assign dens_o  = dens_q;
  assign gated_o = dens_q & tick_i;

endmodule

// File: rtl/pulse_density_mod_chk.sv
module pulse_density_mod_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         tick_i,
  input logic         dens_o,
  input logic         gated_o,
  input logic [W-1:0] cnt_q,
  input logic [W-1:0] lvl_q
);
  localparam logic [W-1:0] HALF = W'(1) << (W-1);

  p_rst_low_r1: assert property (@(posedge clk) rst |=> !dens_o);

  p_lvl_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (tick_i && cnt_q != '0) |=> $stable(lvl_q));

  p_idle_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !tick_i |=> ($stable(dens_o) && $stable(cnt_q)));

  p_gate_r6: assert property (@(posedge clk) disable iff (rst)
    gated_o |-> (dens_o && tick_i));

  p_half_alt_r7: assert property (@(posedge clk) disable iff (rst)
    (lvl_q == HALF && cnt_q != '0) |-> (dens_o == !cnt_q[0]));

  p_zero_low_r8: assert property (@(posedge clk) disable iff (rst)
    (lvl_q == '0 && cnt_q != '0) |-> !dens_o);

endmodule

bind pulse_density_mod pulse_density_mod_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .tick_i(tick_i), .dens_o(dens_o),
  .gated_o(gated_o), .cnt_q(cnt_q), .lvl_q(lvl_q)
);

// File: tb/pulse_density_mod_tb.sv
module pulse_density_mod_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic [7:0] lvl8 = 8'd0;
  logic [2:0] lvl3 = 3'd0;
  logic [1:0] dens, gated;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pulse_density_mod #(.W(8)) u_dut (
    .clk(clk), .rst(rst), .tick_i(tick), .level_i(lvl8),
    .dens_o(dens[0]), .gated_o(gated[0]));

  pulse_density_mod #(.W(3)) u_dut3 (
    .clk(clk), .rst(rst), .tick_i(tick), .level_i(lvl3),
    .dens_o(dens[1]), .gated_o(gated[1]));

  int m_k[2], m_L[2], hits[2];
  bit m_exp[2], m_end[2], m_ptick, m_prst;
  int NN[2] = '{256, 8};

  function automatic bit exp_bit(int j, int L, int N);
    return ((j * L) / N) != (((j - 1) * L) / N);
  endfunction

  function automatic string tag(int L, int N);
    if (L == N / 2) return "R7";
    if (L == 0 || L == N - 1) return "R8";
    return "R3";
  endfunction

  task automatic check(bit ok, string req, int act, int exp_v, int u);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s dut%0d t=%0t actual=%0d expected=%0d", req, u, $time, act, exp_v);
    end
  endtask

  always @(posedge clk) begin
    for (int u = 0; u < 2; u++) begin
      if (rst) begin
        m_k[u] <= 0; m_L[u] <= 0; m_exp[u] <= 1'b0; m_end[u] <= 1'b0;
      end else if (tick) begin
        int L, j;
        L = (m_k[u] == 0) ? ((u == 0) ? int'(lvl8) : int'(lvl3)) : m_L[u];
        j = m_k[u] + 1;
        m_L[u]   <= L;
        m_exp[u] <= exp_bit(j, L, NN[u]);
        m_end[u] <= (j == NN[u]);
        m_k[u]   <= (j == NN[u]) ? 0 : j;
      end
    end
    m_ptick <= tick;
    m_prst  <= rst;
  end

  always @(negedge clk) begin
    if (!done) begin
      for (int u = 0; u < 2; u++) begin
        if (m_prst) begin
          check(dens[u] == 1'b0, "R1", dens[u], 0, u);
          hits[u] = 0;
        end else if (m_ptick) begin
          check(dens[u] == m_exp[u], tag(m_L[u], NN[u]), dens[u], m_exp[u], u);
          hits[u] += dens[u];
          if (m_end[u]) begin
            check(hits[u] == m_L[u], "R2 R4 frame count", hits[u], m_L[u], u);
            hits[u] = 0;
          end
        end else begin
          check(dens[u] == m_exp[u], "R5", dens[u], m_exp[u], u);
        end
        check(gated[u] == (m_exp[u] & tick), "R6", gated[u], m_exp[u] & tick, u);
      end
    end
  end

  task automatic cyc(bit t);
    @(posedge clk); #2;
    tick = t;
    lvl3 = 3'($urandom);
  endtask

  initial begin
    int dir[7] = '{128, 127, 126, 1, 0, 129, 255};
    void'($urandom(32'd1234));
    repeat (3) cyc(1'b0);
    @(posedge clk); #2; rst = 1'b0;
    for (int d = 0; d < 7; d++) begin
      lvl8 = 8'(dir[d]);
      for (int c = 0; c < 256; c++) cyc(1'b1);
    end
    for (int c = 0; c < 12000; c++) begin
      if ($urandom_range(0, 36) == 0) lvl8 = 8'($urandom);
      if (c == 5000) begin
        @(posedge clk); #2; rst = 1'b1;
        @(posedge clk); #2; rst = 1'b0;
      end
      cyc($urandom_range(0, 3) != 0);
    end
    cyc(1'b0);
    @(negedge clk); #1;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    done = 1;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule